// File: doc/BRIEF.md
# Bus Target Command Claim and Single-Phase Disconnect

This block is the front end of a memory-mapped bus target. In the address phase it decodes the 4-bit bus command and decides whether the target claims the transaction. The decision depends on the address-hit input and on whether the bus runs in conventional mode or in the extended (PCI-X) mode. Burst-style and alias commands are folded onto a small set of normalized operations: memory read, memory write, configuration read and configuration write. The register file behind the block only ever sees single-word accesses.

Every claimed transfer is cut short after its first data phase. When the initiator signals that it is ready, the block answers with target ready and stop in the same cycle, so the initiator gets one word and then a disconnect with data. The block holds the claim until the initiator ends the frame, then goes back to idle. A dual-address command makes the block wait for a second address phase and decide on the command carried there.

Top module: `tgt_claim_unit`

## Requirements
- R1: Commands 0000, 0001, 0010, 0011, 0100 and 0101 are never claimed in either bus mode. `claim` stays 0 and `op` stays 0.
- R2: `op` encodes none=0, mem_read=1, mem_write=2, cfg_read=3, cfg_write=4. Command 0110 is claimed as mem_read and 0111 as mem_write in both modes.
- R3: In PCI-X mode (`pcix_mode`=1), 1000 is claimed as mem_read and 1001 as mem_write. In conventional mode both are ignored.
- R4: 1010 is claimed as cfg_read and 1011 as cfg_write in both modes.
- R5: In conventional mode, 1100 and 1110 are claimed as mem_read and 1111 as mem_write. In PCI-X mode, 1110 is mem_read, 1111 is mem_write, and 1100 is not claimed.
- R6: `claim` rises in the cycle after the address strobe, and only if the command is claimable and `addr_hit` is 1 at the strobe.
- R7: In the cycle after `init_ready` is first sampled high during a claimed transfer, `tgt_ready` and `tgt_stop` are both 1 for exactly one cycle. They stay 0 afterwards even if `init_ready` stays high. Neither is ever 1 without `claim`.
- R8: After the data phase, `claim` and `op` hold until `frame_end` is sampled high. In the next cycle `claim` is 0 and `op` is 0.
- R9: A strobe with command 1101 is followed by a second address phase in the very next cycle. The command and hit sampled there decide the claim, which appears one cycle later. If no second strobe arrives, or the second command is 1101, nothing is claimed.
- R10: An address strobe that arrives while a transaction is in progress is ignored. `op` keeps its value and no new claim follows when the block returns to idle.
- R11: If `frame_end` is sampled during a claimed transfer before any data phase, the block releases `claim` in the next cycle and never raises `tgt_ready` or `tgt_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strobe | input | 1 | Address phase valid |
| cmd | input | 4 | Bus command of the address phase |
| addr_hit | input | 1 | Address falls in this target's window |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| init_ready | input | 1 | Initiator ready for a data phase |
| frame_end | input | 1 | Initiator ends the frame |
| claim | output | 1 | Target claims the transaction |
| op | output | 3 | Normalized operation code |
| tgt_ready | output | 1 | Target ready for the data phase |
| tgt_stop | output | 1 | Target requests disconnect |

## Verification
A decode fault, such as an alias mapped to the wrong operation or a mode-dependent command claimed in the wrong mode, shows as a wrong `claim` or `op` in the single cycle after the strobe. A phase-state fault shows within one or two cycles of `init_ready` or `frame_end`:
- `tgt_ready` and `tgt_stop` split apart or repeat,
- `claim` holds past the end of the frame, or
- a strobe that should be ignored changes `op`.

A dual-address fault shows as a claim one cycle too early or a claim on a lone first phase.

// File: rtl/tgt_claim_pkg.sv
package tgt_claim_pkg;

    localparam int CMD_W = 4;
    localparam int OP_W  = 3;

    localparam logic [CMD_W-1:0] CMD_MEM_RD   = 4'b0110;
    localparam logic [CMD_W-1:0] CMD_MEM_WR   = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_BLK_RD   = 4'b1000;
    localparam logic [CMD_W-1:0] CMD_BLK_WR   = 4'b1001;
    localparam logic [CMD_W-1:0] CMD_CFG_RD   = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WR   = 4'b1011;
    localparam logic [CMD_W-1:0] CMD_RD_MULTI = 4'b1100;
    localparam logic [CMD_W-1:0] CMD_DUAL_ADR = 4'b1101;
    localparam logic [CMD_W-1:0] CMD_RD_LINE  = 4'b1110;
    localparam logic [CMD_W-1:0] CMD_WR_INVAL = 4'b1111;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 3'd0,
        OP_MEM_RD = 3'd1,
        OP_MEM_WR = 3'd2,
        OP_CFG_RD = 3'd3,
        OP_CFG_WR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DUAL2,
        ST_XFER,
        ST_FINISH
    } phase_e;

endpackage

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
    import tgt_claim_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             pcix_mode,
    output logic             claimable,
    output logic             is_dual,
    output op_e              op_norm
);

    always_comb begin
        claimable = 1'b0;
        op_norm   = OP_NONE;
        is_dual   = (cmd == CMD_DUAL_ADR);
        case (cmd)
            CMD_MEM_RD: begin
                claimable = 1'b1;
                op_norm   = OP_MEM_RD;
            end
            CMD_MEM_WR: begin
                claimable = 1'b1;
                op_norm   = OP_MEM_WR;
            end
            CMD_BLK_RD: begin
                if (pcix_mode) begin
                    claimable = 1'b1;
                    op_norm   = OP_MEM_RD;
                end
            end
            CMD_BLK_WR: begin
                if (pcix_mode) begin
                    claimable = 1'b1;
                    op_norm   = OP_MEM_WR;
                end
            end
            CMD_CFG_RD: begin
                claimable = 1'b1;
                op_norm   = OP_CFG_RD;
            end
            CMD_CFG_WR: begin
                claimable = 1'b1;
                op_norm   = OP_CFG_WR;
            end
            CMD_RD_MULTI: begin
                if (!pcix_mode) begin
                    claimable = 1'b1;
                    op_norm   = OP_MEM_RD;
                end
            end
            CMD_RD_LINE: begin
                claimable = 1'b1;
                op_norm   = OP_MEM_RD;
            end
            CMD_WR_INVAL: begin
                claimable = 1'b1;
                op_norm   = OP_MEM_WR;
            end
            default: begin
                claimable = 1'b0;
                op_norm   = OP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/tgt_phase_ctrl.sv
module tgt_phase_ctrl
    import tgt_claim_pkg::*;
#(
    parameter int PHASES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_strobe,
    input  logic addr_hit,
    input  logic claimable,
    input  logic is_dual,
    input  op_e  op_norm,
    input  logic init_ready,
    input  logic frame_end,
    output logic claim,
    output op_e  op,
    output logic tgt_ready,
    output logic tgt_stop
);

    localparam int CNT_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(PHASES - 1);

    typedef struct packed {
        phase_e           state;
        logic             claim;
        op_e              op;
        logic             ready;
        logic             stop;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic take_d;
    assign take_d = addr_strobe && !is_dual && claimable && addr_hit;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.ready = 1'b0;
        nxt_d.stop  = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (addr_strobe && is_dual) begin
                    nxt_d.state = ST_DUAL2;
                end else if (take_d) begin
                    nxt_d.state = ST_XFER;
                    nxt_d.claim = 1'b1;
                    nxt_d.op    = op_norm;
                    nxt_d.cnt   = '0;
                end
            end
            ST_DUAL2: begin
                nxt_d.state = ST_IDLE;
                if (take_d) begin
                    nxt_d.state = ST_XFER;
                    nxt_d.claim = 1'b1;
                    nxt_d.op    = op_norm;
                    nxt_d.cnt   = '0;
                end
            end
            ST_XFER: begin
                if (init_ready) begin
                    nxt_d.ready = 1'b1;
                    if (cur_q.cnt == LAST_PHASE) begin
                        nxt_d.stop  = 1'b1;
                        nxt_d.state = ST_FINISH;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end else if (frame_end) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.claim = 1'b0;
                    nxt_d.op    = OP_NONE;
                end
            end
            ST_FINISH: begin
                if (frame_end) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.claim = 1'b0;
                    nxt_d.op    = OP_NONE;
                end
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.claim = 1'b0;
                nxt_d.op    = OP_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.claim <= 1'b0;
            cur_q.op    <= OP_NONE;
            cur_q.ready <= 1'b0;
            cur_q.stop  <= 1'b0;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign claim     = cur_q.claim;
    assign op        = cur_q.op;
    assign tgt_ready = cur_q.ready;
    assign tgt_stop  = cur_q.stop;

endmodule

// File: rtl/tgt_claim_unit.sv
module tgt_claim_unit
    import tgt_claim_pkg::*;
#(
    parameter int PHASES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_strobe,
    input  logic [CMD_W-1:0] cmd,
    input  logic             addr_hit,
    input  logic             pcix_mode,
    input  logic             init_ready,
    input  logic             frame_end,
    output logic             claim,
    output logic [OP_W-1:0]  op,
    output logic             tgt_ready,
    output logic             tgt_stop
);

    logic claimable_w;
    logic is_dual_w;
    op_e  op_norm_w;
    op_e  op_w;

    tgt_cmd_decode u_dec (
        .cmd       (cmd),
        .pcix_mode (pcix_mode),
        .claimable (claimable_w),
        .is_dual   (is_dual_w),
        .op_norm   (op_norm_w)
    );

    tgt_phase_ctrl #(.PHASES(PHASES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_strobe (addr_strobe),
        .addr_hit    (addr_hit),
        .claimable   (claimable_w),
        .is_dual     (is_dual_w),
        .op_norm     (op_norm_w),
        .init_ready  (init_ready),
        .frame_end   (frame_end),
        .claim       (claim),
        .op          (op_w),
        .tgt_ready   (tgt_ready),
        .tgt_stop    (tgt_stop)
    );

    assign op = op_w;

endmodule

// File: rtl/tgt_claim_chk.sv
module tgt_claim_chk
    import tgt_claim_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            addr_strobe,
    input logic            frame_end,
    input logic            claim,
    input logic [OP_W-1:0] op,
    input logic            tgt_ready,
    input logic            tgt_stop
);

    assert_op_none_unclaimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> (op == 3'd0));

    assert_claim_has_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (op != 3'd0 && op <= 3'd4));

    assert_phase_needs_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_ready || tgt_stop) |-> claim);

    assert_stop_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_stop |-> tgt_ready);

    assert_quiet_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_stop |=> (!tgt_ready && !tgt_stop));

    assert_claim_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim) |-> $past(addr_strobe));

    assert_release_on_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(claim) |-> $past(frame_end));

    assert_op_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && $past(claim)) |-> $stable(op));

endmodule

bind tgt_claim_unit tgt_claim_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_strobe (addr_strobe),
    .frame_end   (frame_end),
    .claim       (claim),
    .op          (op),
    .tgt_ready   (tgt_ready),
    .tgt_stop    (tgt_stop)
);

// File: tb/sim_tgt_claim_unit.sv
module sim_tgt_claim_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strobe = 1'b0;
    logic [3:0] cmd = 4'd0;
    logic       addr_hit = 1'b0;
    logic       pcix_mode = 1'b0;
    logic       init_ready = 1'b0;
    logic       frame_end = 1'b0;
    logic       claim;
    logic [2:0] op;
    logic       tgt_ready;
    logic       tgt_stop;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       c;
        logic [2:0] o;
        logic       r;
        logic       s;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    tgt_claim_unit u0 (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .cmd(cmd),
        .addr_hit(addr_hit), .pcix_mode(pcix_mode), .init_ready(init_ready),
        .frame_end(frame_end), .claim(claim), .op(op),
        .tgt_ready(tgt_ready), .tgt_stop(tgt_stop)
    );

    // Scoreboard monitor: 2 ns after each falling edge, compare every queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (claim !== e.c || op !== e.o || tgt_ready !== e.r || tgt_stop !== e.s) begin
                    n_bad++;
                    $display("FAIL %s: got claim=%0b op=%0d rdy=%0b stop=%0b, expected claim=%0b op=%0d rdy=%0b stop=%0b",
                             e.tag, claim, op, tgt_ready, tgt_stop, e.c, e.o, e.r, e.s);
                end
            end
        end
    end

    task automatic expect_now(input logic c, input logic [2:0] o, input logic r,
                              input logic s, input string tag);
        exp_t e;
        e.c = c; e.o = o; e.r = r; e.s = s; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic strobe(input logic [3:0] c, input logic hit);
        @(negedge clk);
        addr_strobe = 1'b1; cmd = c; addr_hit = hit;
        @(negedge clk);
        addr_strobe = 1'b0; addr_hit = 1'b0;
    endtask

    // Full transfer: strobe, check decision, run one data phase, hold, end frame
    task automatic txn(input logic mode, input logic [3:0] c, input logic hit,
                       input logic exp_c, input logic [2:0] exp_o, input string tag);
        pcix_mode = mode;
        strobe(c, hit);
        expect_now(exp_c, exp_o, 1'b0, 1'b0, {tag, " decide"});
        if (exp_c) begin
            init_ready = 1'b1;
            @(negedge clk);
            init_ready = 1'b0;
            expect_now(1'b1, exp_o, 1'b1, 1'b1, {tag, " R7 phase"});
            @(negedge clk);
            expect_now(1'b1, exp_o, 1'b0, 1'b0, {tag, " R8 hold"});
            frame_end = 1'b1;
            @(negedge clk);
            frame_end = 1'b0;
            expect_now(1'b0, 3'd0, 1'b0, 1'b0, {tag, " R8 release"});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "reset state");
        rst_n = 1'b1;

        // R1: never claimed, both modes
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 6; k++)
                txn(m[0], 4'(k), 1'b1, 1'b0, 3'd0, "R1 unclaimed");

        // R2
        txn(1'b0, 4'b0110, 1'b1, 1'b1, 3'd1, "R2 mem read conv");
        txn(1'b1, 4'b0110, 1'b1, 1'b1, 3'd1, "R2 mem read pcix");
        txn(1'b0, 4'b0111, 1'b1, 1'b1, 3'd2, "R2 mem write conv");
        txn(1'b1, 4'b0111, 1'b1, 1'b1, 3'd2, "R2 mem write pcix");

        // R3
        txn(1'b1, 4'b1000, 1'b1, 1'b1, 3'd1, "R3 block read pcix");
        txn(1'b1, 4'b1001, 1'b1, 1'b1, 3'd2, "R3 block write pcix");
        txn(1'b0, 4'b1000, 1'b1, 1'b0, 3'd0, "R3 1000 conv ignored");
        txn(1'b0, 4'b1001, 1'b1, 1'b0, 3'd0, "R3 1001 conv ignored");

        // R4
        txn(1'b0, 4'b1010, 1'b1, 1'b1, 3'd3, "R4 cfg read conv");
        txn(1'b1, 4'b1011, 1'b1, 1'b1, 3'd4, "R4 cfg write pcix");

        // R5
        txn(1'b0, 4'b1100, 1'b1, 1'b1, 3'd1, "R5 read multi conv");
        txn(1'b0, 4'b1110, 1'b1, 1'b1, 3'd1, "R5 read line conv");
        txn(1'b0, 4'b1111, 1'b1, 1'b1, 3'd2, "R5 write inval conv");
        txn(1'b1, 4'b1110, 1'b1, 1'b1, 3'd1, "R5 1110 pcix");
        txn(1'b1, 4'b1111, 1'b1, 1'b1, 3'd2, "R5 1111 pcix");
        txn(1'b1, 4'b1100, 1'b1, 1'b0, 3'd0, "R5 1100 pcix ignored");

        // R6: no hit
        txn(1'b0, 4'b0110, 1'b0, 1'b0, 3'd0, "R6 miss");

        // R7: initiator keeps ready high for a long burst
        pcix_mode = 1'b0;
        strobe(4'b0111, 1'b1);
        expect_now(1'b1, 3'd2, 1'b0, 1'b0, "R6 claim timing");
        init_ready = 1'b1;
        @(negedge clk);
        expect_now(1'b1, 3'd2, 1'b1, 1'b1, "R7 first phase");
        @(negedge clk);
        expect_now(1'b1, 3'd2, 1'b0, 1'b0, "R7 no second phase");
        @(negedge clk);
        expect_now(1'b1, 3'd2, 1'b0, 1'b0, "R7 still stopped");
        init_ready = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R8 release after burst");

        // R10: strobe in progress ignored
        strobe(4'b1010, 1'b1);
        expect_now(1'b1, 3'd3, 1'b0, 1'b0, "R10 setup claim");
        strobe(4'b0111, 1'b1);
        expect_now(1'b1, 3'd3, 1'b0, 1'b0, "R10 op unchanged");
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R10 release");
        @(negedge clk);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R10 no late claim");

        // R11: frame ends before any data phase
        strobe(4'b0110, 1'b1);
        expect_now(1'b1, 3'd1, 1'b0, 1'b0, "R11 claim");
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R11 early release");
        @(negedge clk);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R11 no phase");

        // R9: dual address, then memory write
        @(negedge clk);
        addr_strobe = 1'b1; cmd = 4'b1101; addr_hit = 1'b1;
        @(negedge clk);
        cmd = 4'b0111;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 no claim on first phase");
        @(negedge clk);
        addr_strobe = 1'b0; addr_hit = 1'b0;
        expect_now(1'b1, 3'd2, 1'b0, 1'b0, "R9 claim after second phase");
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 release");

        // R9: lone dual phase, nothing follows
        strobe(4'b1101, 1'b1);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 lone first");
        @(negedge clk);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 lone no claim");

        // R9: dual followed by dual
        @(negedge clk);
        addr_strobe = 1'b1; cmd = 4'b1101; addr_hit = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr_strobe = 1'b0; addr_hit = 1'b0;
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 dual twice");
        @(negedge clk);
        expect_now(1'b0, 3'd0, 1'b0, 1'b0, "R9 dual twice later");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule